// File: doc/BRIEF.md
# Set/Clear Addressed Output Port

This block is a parallel output port whose state lives in one internal bit register. Software never loads that register with a plain value. It issues one of two address-triggered commands instead. A write to the set address turns on every register bit that has a 1 in the write data. A write to the clear address turns off every register bit that has a 1 in the write data. Data bits that are 0 leave their register bits alone, so single pins can be changed without a read-modify-write.

Each pin carries the inverse of its register bit. A bit at 1 pulls its pin low. A bit at 0 lets the pin float high. For wired-OR sharing on an external line, every pin has a pull-low enable and a release signal. A push-pull level copy of each pin is also brought out for simulation and for loads that need a driven level, and a read port returns the register contents.

Top module: `opport_setclr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `reg_q` is all zeros, `pad_lvl` is all ones, `pad_oe` is all zeros and `pad_rel` is all ones.
- R2: A clock edge with `sel`=1, `wr`=1 and `addr`=SET_ADDR (default 4'hE) makes `reg_q` equal its old value OR `wdata`.
- R3: A clock edge with `sel`=1, `wr`=1 and `addr`=CLR_ADDR (default 4'hF) makes `reg_q` equal its old value AND NOT `wdata`.
- R4: A data bit of 0 leaves its register bit unchanged under both commands, so an all-zero mask changes nothing.
- R5: `pad_lvl[i]` is always the complement of `reg_q[i]`.
- R6: `pad_oe[i]` (1 = pull pin low) equals `reg_q[i]`, and `pad_rel[i]` (1 = pin released to its external pull-up) is its complement.
- R7: A write with `sel`=1 and `wr`=1 to any address other than the two command addresses leaves `reg_q` unchanged.
- R8: With `sel`=0 or `wr`=0, `reg_q` is unchanged whatever `addr` and `wdata` hold.
- R9: A command takes effect at the clock edge that samples it; before that edge `reg_q` and the pins still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | ADDR_W | Command address |
| wdata | input | WIDTH | Bit mask for the command |
| reg_q | output | WIDTH | Current register contents (read port) |
| pad_lvl | output | WIDTH | Push-pull pin level, complement of the register |
| pad_oe | output | WIDTH | Per-pin pull-low enable for open-drain use |
| pad_rel | output | WIDTH | Per-pin release indicator (pin floats high) |

## Verification
The properties assume that `sel`, `wr`, `addr` and `wdata` are settled before each rising edge, and that nothing outside the block drives the pins. They also assume that reset is held for at least one edge, so the register starts from a known value. The bench changes every input on the falling edge, half a period from any sampling edge. It asserts reset for several cycles before the first command and again in the middle of the run, so every clocked property sees only stable, defined inputs.

// File: rtl/opport_pkg.sv
// Package: shared types for the set/clear output port.
// Assumes: exactly one command can be decoded per cycle.
package opport_pkg;

    // Decoded command kind for a single clock cycle.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2
    } opcmd_t;

endpackage

// File: rtl/opport_cmd_dec.sv
// Module: opport_cmd_dec
// Turns a bus write into a set, clear or no-op command and passes the mask on.
// Assumes: SET_ADDR and CLR_ADDR differ, so the two commands never collide.
module opport_cmd_dec
    import opport_pkg::*;
#(
    parameter int                WIDTH    = 8,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] SET_ADDR = 4'hE,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 4'hF
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output opcmd_t            cmd,
    output logic [WIDTH-1:0]  mask
);

    logic strobe;

    // Qualify a bus write: select and write strobe must both be high.
    always_comb begin
        strobe = sel & wr;
    end

    // Match the address against the two command slots.
    always_comb begin
        cmd = CMD_NONE;
        if (strobe) begin
            if (addr == SET_ADDR) begin
                cmd = CMD_SET;
            end else if (addr == CLR_ADDR) begin
                cmd = CMD_CLR;
            end
        end
    end

    // Pass the data through as the bit mask.
    always_comb begin
        mask = wdata;
    end

endmodule

// File: rtl/opport_bitreg.sv
// Module: opport_bitreg
// Holds the port register and applies masked set/clear commands.
// Assumes: reset is synchronous and active low; the command is settled at the edge.
module opport_bitreg
    import opport_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  opcmd_t           cmd,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_next;

    // Work out the next register value from the command and mask.
    always_comb begin
        unique case (cmd)
            CMD_SET: q_next = q | mask;
            CMD_CLR: q_next = q & ~mask;
            default: q_next = q;
        endcase
    end

    // Update the register on the clock edge, or clear it during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/opport_pad.sv
// Module: opport_pad
// Pin driver for one bit: inverted level, pull-low enable, release flag.
// Assumes: an external pull-up holds a released pin high.
module opport_pad (
    input  logic bit_q,
    output logic lvl,
    output logic oe,
    output logic rel
);

    // Pin is low while the bit is set, so it carries the inverse of the bit.
    always_comb begin
        lvl = ~bit_q;
        oe  = bit_q;
        rel = ~bit_q;
    end

endmodule

// File: rtl/opport_setclr.sv
// Module: opport_setclr (top)
// Output port driven only by address-triggered set and clear commands.
// Pins show the inverse of the register and can be used open-drain.
// Assumes: synchronous active-low reset; one command per cycle.
module opport_setclr
    import opport_pkg::*;
#(
    parameter int                WIDTH    = 8,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] SET_ADDR = 4'hE,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  reg_q,
    output logic [WIDTH-1:0]  pad_lvl,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_rel
);

    opcmd_t           cmd;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] q;

    opport_cmd_dec #(
        .WIDTH   (WIDTH),
        .ADDR_W  (ADDR_W),
        .SET_ADDR(SET_ADDR),
        .CLR_ADDR(CLR_ADDR)
    ) u_dec (
        .sel  (sel),
        .wr   (wr),
        .addr (addr),
        .wdata(wdata),
        .cmd  (cmd),
        .mask (mask)
    );

    opport_bitreg #(
        .WIDTH(WIDTH)
    ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .mask (mask),
        .q    (q)
    );

    // One pin driver for each register bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        opport_pad u_pad (
            .bit_q(q[i]),
            .lvl  (pad_lvl[i]),
            .oe   (pad_oe[i]),
            .rel  (pad_rel[i])
        );
    end

    // Bring the register out on the read port.
    always_comb begin
        reg_q = q;
    end

endmodule

// File: rtl/opport_setclr_chk.sv
// Module: opport_setclr_chk
// Property checker for opport_setclr, attached through bind.
// Assumes: inputs settle before each rising edge.
module opport_setclr_chk #(
    parameter int                WIDTH    = 8,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] SET_ADDR = 4'hE,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 4'hF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wdata,
    input logic [WIDTH-1:0]  reg_q,
    input logic [WIDTH-1:0]  pad_lvl,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_rel
);

    logic do_set;
    logic do_clr;

    // Name the two command conditions seen at the port.
    always_comb begin
        do_set = sel && wr && (addr == SET_ADDR);
        do_clr = sel && wr && (addr == CLR_ADDR);
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (reg_q == '0 && pad_lvl == '1));

    p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_set |=> (reg_q == ($past(reg_q) | $past(wdata))));

    p_clr_andn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> (reg_q == ($past(reg_q) & ~$past(wdata))));

    p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((do_set || do_clr) && wdata == '0) |=> $stable(reg_q));

    p_level_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_lvl == ~reg_q);

    p_oe_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe == reg_q) && (pad_rel == ~pad_oe));

    p_other_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr != SET_ADDR && addr != CLR_ADDR) |=> $stable(reg_q));

    p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || !wr) |=> $stable(reg_q));

endmodule

bind opport_setclr opport_setclr_chk #(
    .WIDTH   (WIDTH),
    .ADDR_W  (ADDR_W),
    .SET_ADDR(SET_ADDR),
    .CLR_ADDR(CLR_ADDR)
) u_chk (.*);

// File: tb/sim_opport_setclr.sv
// Bench for opport_setclr: a table of command vectors, then directed tests.
module sim_opport_setclr;

    localparam int WIDTH = 8;
    localparam int ADDR_W = 4;
    localparam logic [3:0] A_SET = 4'hE;
    localparam logic [3:0] A_CLR = 4'hF;
    localparam int NV = 12;

    // Vector: {sel, wr, addr[3:0], wdata[7:0], expected reg[7:0], tag[3:0]}
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 1'b1, A_SET, 8'h81, 8'h81, 4'd2},
        {1'b1, 1'b1, A_SET, 8'h00, 8'h81, 4'd4},
        {1'b1, 1'b1, A_CLR, 8'h01, 8'h80, 4'd3},
        {1'b1, 1'b1, A_SET, 8'h3C, 8'hBC, 4'd2},
        {1'b1, 1'b1, A_CLR, 8'h00, 8'hBC, 4'd4},
        {1'b1, 1'b1, 4'h5,  8'hFF, 8'hBC, 4'd7},
        {1'b0, 1'b1, A_SET, 8'hFF, 8'hBC, 4'd8},
        {1'b1, 1'b0, A_CLR, 8'hFF, 8'hBC, 4'd8},
        {1'b1, 1'b1, A_SET, 8'hFF, 8'hFF, 4'd2},
        {1'b1, 1'b1, A_CLR, 8'hAA, 8'h55, 4'd3},
        {1'b1, 1'b1, A_CLR, 8'hFF, 8'h00, 4'd3},
        {1'b1, 1'b1, A_SET, 8'h10, 8'h10, 4'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WIDTH-1:0]  wdata = '0;
    logic [WIDTH-1:0]  reg_q;
    logic [WIDTH-1:0]  pad_lvl;
    logic [WIDTH-1:0]  pad_oe;
    logic [WIDTH-1:0]  pad_rel;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opport_setclr u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .wr     (wr),
        .addr   (addr),
        .wdata  (wdata),
        .reg_q  (reg_q),
        .pad_lvl(pad_lvl),
        .pad_oe (pad_oe),
        .pad_rel(pad_rel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check the register and all three pin views against one expected value.
    task automatic check_all(input string req, input logic [7:0] exp);
        check({req, " reg"}, reg_q, exp);
        check("R5 pad_lvl", pad_lvl, ~exp);
        check("R6 pad_oe", pad_oe, exp);
        check("R6 pad_rel", pad_rel, ~exp);
    endtask

    task automatic idle();
        sel = 1'b0;
        wr = 1'b0;
        addr = '0;
        wdata = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during reset and right after release.
        repeat (3) @(negedge clk);
        check_all("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 8'h00);

        // Table walk: drive at falling edge, sample at the next falling edge.
        for (int i = 0; i < NV; i++) begin
            sel = VEC[i][25];
            wr = VEC[i][24];
            addr = VEC[i][23:20];
            wdata = VEC[i][19:12];
            @(negedge clk);
            idle();
            check_all($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][11:4]);
        end

        // R9: value holds until the sampling edge, then changes.
        sel = 1'b1; wr = 1'b1; addr = A_SET; wdata = 8'h0F;
        @(posedge clk);
        #1;
        check("R9 after edge", reg_q, 8'h1F);
        @(negedge clk);
        idle();
        sel = 1'b1; wr = 1'b1; addr = A_CLR; wdata = 8'h10;
        #2;
        check("R9 before edge", reg_q, 8'h1F);
        check("R9 before edge pin", pad_lvl, 8'hE0);
        @(negedge clk);
        idle();
        check_all("R9", 8'h0F);

        // R7: every non-command address with a full mask, both polarities.
        for (int a = 0; a < 14; a++) begin
            sel = 1'b1; wr = 1'b1; addr = 4'(a); wdata = 8'hFF;
            @(negedge clk);
        end
        idle();
        check("R7 sweep", reg_q, 8'h0F);

        // R1: reset in the middle of operation clears the register.
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 midrun", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", reg_q, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule